// File: doc/BRIEF.md
# Serial Bitstream Configuration Master

This block loads a configuration image into a programmable target device over a one-bit serial link. The target has an active-low program request, a serial configuration clock, a serial data line, and two status lines. The first is an active-low init line that the target holds low while it clears itself and also pulls low on a checksum fault. The second is a done line that rises once the image has been accepted. A host starts a load with a one-cycle start pulse and a total byte count, and then supplies the image bytes on a valid/ready byte stream.

The block first asserts the program request and waits for init to go low. It then releases the request and waits for init to return high. After that it sends each byte most significant bit first, changing the data line while the configuration clock is low and raising the clock to present each bit. Before each byte it checks for a checksum fault. After the last byte it holds the data line high and keeps the clock running until done rises. Each of the three waits has its own timeout, measured in system clock cycles and derived from the clock frequency and a wait time in microseconds. The configuration clock is the system clock divided down so that it never exceeds a configurable maximum rate.

Top module: `cfg_serial_loader`

## Requirements
- R1: A start pulse while idle or finished drives `prog_n_o` low from the next cycle. It stays low until `init_n_i` is sampled low. If `init_n_i` is still high after TMO cycles in this phase, the load ends with status 2.
- R2: Once `init_n_i` is sampled low, `prog_n_o` returns high and the block waits for `init_n_i` to be high. No byte is requested and the clock stays low during this wait. After TMO cycles of waiting, the load ends with status 3.
- R3: Each wait phase lasts at most TMO = (CLK_HZ/1e6)*WAIT_US cycles. The phase that expired is reported with its own code: 2 for program, 3 for init release, 4 for done.
- R4: Bytes are sent MSB first. `din_o` changes only while `cclk_o` is low and holds its value while `cclk_o` is high. Each clock half period lasts HALF = ceil(CLK_HZ/(2*CCLK_MAX_HZ)) system cycles.
- R5: Before each byte, if `init_n_i` is low while `done_i` is low, the load ends with status 5. No further clock edges follow.
- R6: After the last byte, `din_o` is held at 1 and `cclk_o` keeps toggling. When `done_i` is sampled high the load ends with status 1. If `done_i` stays low for TMO cycles, the load ends with status 4.
- R7: `byte_ready_o` is high only when the previous byte has been fully sent, bytes remain to be sent, and no checksum fault is present. A byte is taken on a cycle where both `byte_valid_i` and `byte_ready_o` are high.
- R8: `busy_o` is high from the cycle after an accepted start until the final status is latched. At that point `status_valid_o` goes high and stays high, with `status_o` held, until the next start. A start pulse while busy has no effect.
- R9: A byte count of zero skips data entirely and goes straight from the init release to the done phase.
- R10: After reset, `prog_n_o` is 1, `cclk_o` is 0, `din_o` is 1, `busy_o`, `byte_ready_o` and `status_valid_o` are 0, and `status_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a load |
| total_bytes_i | input | COUNT_W | Number of image bytes, captured with the start pulse |
| byte_data_i | input | 8 | Image byte |
| byte_valid_i | input | 1 | Image byte is present |
| byte_ready_o | output | 1 | Block accepts the image byte this cycle |
| prog_n_o | output | 1 | Program request to the target, active low |
| cclk_o | output | 1 | Configuration clock to the target |
| din_o | output | 1 | Serial configuration data to the target |
| init_n_i | input | 1 | Target init line, active low |
| done_i | input | 1 | Target done line |
| busy_o | output | 1 | Load in progress |
| status_valid_o | output | 1 | Final status is present |
| status_o | output | 3 | 0 none, 1 success, 2 program timeout, 3 init-release timeout, 4 done timeout, 5 checksum fault |

## Verification
A behavioural model of the link is compared with the block on every cycle while a modelled target reacts to the program, clock and data lines. The normal loads use bytes with alternating, all-zero, all-one and asymmetric bit patterns, so that a reversed bit order or an off-by-one shift shows up in the bytes the target captures. Some loads feed bytes back to back and others leave idle gaps on the stream, which separates correct ready handling from a block that assumes data is always present. The target is then made to misbehave at each handshake point in turn (init never falls, init never releases, done never rises, a fault raised mid-image), and a load with a zero byte count is run, so that each ending status can only be reached by its own path. A second start pulse during a load checks that a request made while busy is ignored.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_REL   = 3'd2,
    ST_FETCH = 3'd3,
    ST_SHIFT = 3'd4,
    ST_FLUSH = 3'd5,
    ST_FIN   = 3'd6
  } ld_state_e;

  typedef enum logic [2:0] {
    LS_NONE     = 3'd0,
    LS_OK       = 3'd1,
    LS_TMO_PROG = 3'd2,
    LS_TMO_INIT = 3'd3,
    LS_TMO_DONE = 3'd4,
    LS_CRC      = 3'd5
  } ld_status_e;

endpackage

// File: rtl/cfg_ld_divider.sv
module cfg_ld_divider #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic cclk,
  output logic fall_tick
);

  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cclk_q, cclk_d;
  logic          tick;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    cclk_d = cclk_q;
    if (restart) begin
      cnt_d  = '0;
      cclk_d = 1'b0;
    end else if (run) begin
      if (tick) begin
        cnt_d  = '0;
        cclk_d = ~cclk_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cclk_q <= cclk_d;
    end
  end

  assign cclk      = cclk_q;
  assign fall_tick = tick && cclk_q;

endmodule

// File: rtl/cfg_ld_timer.sv
module cfg_ld_timer #(
  parameter int LIMIT = 500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);

  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)
      cnt_d = '0;
    else if (run && (cnt_q != LAST))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q == LAST);

endmodule

// File: rtl/cfg_ld_shifter.sv
module cfg_ld_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] data,
  input  logic            shift,
  output logic            msb,
  output logic            last_bit
);

  localparam int BW = $clog2(BITS);

  logic [BITS-1:0] sh_q, sh_d;
  logic [BW-1:0]   bit_q, bit_d;

  always_comb begin
    sh_d  = sh_q;
    bit_d = bit_q;
    if (load) begin
      sh_d  = data;
      bit_d = '0;
    end else if (shift) begin
      sh_d  = {sh_q[BITS-2:0], 1'b0};
      bit_d = bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bit_q <= '0;
    end else begin
      sh_q  <= sh_d;
      bit_q <= bit_d;
    end
  end

  assign msb      = sh_q[BITS-1];
  assign last_bit = (bit_q == BW'(BITS - 1));

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_ld_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int CCLK_MAX_HZ = 20_000_000,
  parameter int WAIT_US     = 10_000,
  parameter int COUNT_W     = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [COUNT_W-1:0] total_bytes_i,
  input  logic [7:0]         byte_data_i,
  input  logic               byte_valid_i,
  output logic               byte_ready_o,
  output logic               prog_n_o,
  output logic               cclk_o,
  output logic               din_o,
  input  logic               init_n_i,
  input  logic               done_i,
  output logic               busy_o,
  output logic               status_valid_o,
  output logic [2:0]         status_o
);

  localparam int HALF_RAW   = (CLK_HZ + 2 * CCLK_MAX_HZ - 1) / (2 * CCLK_MAX_HZ);
  localparam int HALF       = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int TMO_RAW    = (CLK_HZ / 1_000_000) * WAIT_US;
  localparam int TMO_CYCLES = (TMO_RAW < 2) ? 2 : TMO_RAW;

  ld_state_e          state_q, state_d;
  ld_status_e         stat_q, stat_d;
  logic [COUNT_W-1:0] rem_q, rem_d;

  logic fault_seen, take_byte, restart, div_run, tmr_run;
  logic tmr_exp, fall_tick, msb, last_bit, shift_en, rem_zero;

  assign fault_seen = !init_n_i && !done_i;
  assign rem_zero   = (rem_q == '0);
  assign take_byte  = byte_ready_o && byte_valid_i;
  assign restart    = (state_q != state_d);
  assign div_run    = (state_q == ST_SHIFT) || (state_q == ST_FLUSH);
  assign tmr_run    = (state_q == ST_PROG) || (state_q == ST_REL) ||
                      (state_q == ST_FLUSH);
  assign shift_en   = (state_q == ST_SHIFT) && fall_tick;

  always_comb begin
    state_d = state_q;
    stat_d  = stat_q;
    rem_d   = rem_q;
    unique case (state_q)
      ST_IDLE, ST_FIN: begin
        if (start_i) begin
          state_d = ST_PROG;
          stat_d  = LS_NONE;
          rem_d   = total_bytes_i;
        end
      end
      ST_PROG: begin
        if (!init_n_i) begin
          state_d = ST_REL;
        end else if (tmr_exp) begin
          state_d = ST_FIN;
          stat_d  = LS_TMO_PROG;
        end
      end
      ST_REL: begin
        if (init_n_i) begin
          state_d = ST_FETCH;
        end else if (tmr_exp) begin
          state_d = ST_FIN;
          stat_d  = LS_TMO_INIT;
        end
      end
      ST_FETCH: begin
        if (rem_zero) begin
          state_d = ST_FLUSH;
        end else if (fault_seen) begin
          state_d = ST_FIN;
          stat_d  = LS_CRC;
        end else if (take_byte) begin
          state_d = ST_SHIFT;
          rem_d   = rem_q - 1'b1;
        end
      end
      ST_SHIFT: begin
        if (fall_tick && last_bit)
          state_d = rem_zero ? ST_FLUSH : ST_FETCH;
      end
      ST_FLUSH: begin
        if (done_i) begin
          state_d = ST_FIN;
          stat_d  = LS_OK;
        end else if (tmr_exp) begin
          state_d = ST_FIN;
          stat_d  = LS_TMO_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      stat_q  <= LS_NONE;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      stat_q  <= stat_d;
      rem_q   <= rem_d;
    end
  end

  cfg_ld_divider #(.HALF(HALF)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .run       (div_run),
    .cclk      (cclk_o),
    .fall_tick (fall_tick)
  );

  cfg_ld_timer #(.LIMIT(TMO_CYCLES)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .run     (tmr_run),
    .expired (tmr_exp)
  );

  cfg_ld_shifter #(.BITS(8)) u_shf (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take_byte),
    .data     (byte_data_i),
    .shift    (shift_en),
    .msb      (msb),
    .last_bit (last_bit)
  );

  assign byte_ready_o   = (state_q == ST_FETCH) && !rem_zero && !fault_seen;
  assign prog_n_o       = (state_q != ST_PROG);
  assign din_o          = (state_q == ST_SHIFT) ? msb : 1'b1;
  assign busy_o         = (state_q != ST_IDLE) && (state_q != ST_FIN);
  assign status_valid_o = (state_q == ST_FIN);
  assign status_o       = stat_q;

endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int WAIT_US = 10_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_ready_o,
  input logic       prog_n_o,
  input logic       cclk_o,
  input logic       din_o,
  input logic       busy_o,
  input logic       status_valid_o,
  input logic [2:0] status_o
);

  localparam int TMO_RAW = (CLK_HZ / 1_000_000) * WAIT_US;
  localparam int TMO     = (TMO_RAW < 2) ? 2 : TMO_RAW;

  int unsigned prog_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prog_low_cnt <= 0;
    else if (prog_n_o) prog_low_cnt <= 0;
    else               prog_low_cnt <= prog_low_cnt + 1;
  end

  // R1: program request goes low together with the rise of busy
  a_r1_prog_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !prog_n_o);

  // R3: program phase never lasts longer than the timeout window
  a_r3_prog_window: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> (prog_low_cnt < TMO));

  // R4: data line holds while the configuration clock is high
  a_r4_din_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk_o && $past(cclk_o)) |-> $stable(din_o));

  // R4: data line does not move on a rising clock
  a_r4_din_hold_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk_o) |-> $stable(din_o));

  // R5: no clock activity once a checksum fault is reported
  a_r5_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (status_valid_o && status_o == 3'd5) |-> !cclk_o);

  // R7: bytes are only requested during the data phase of a load
  a_r7_ready_in_load: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready_o |-> (busy_o && prog_n_o && !cclk_o));

  // R8: busy ends only with a final status present
  a_r8_busy_to_status: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (status_valid_o && status_o != 3'd0));

  // R8: status and busy are never high together
  a_r8_status_excl: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid_o |-> !busy_o);

endmodule

bind cfg_serial_loader cfg_serial_loader_chk #(
  .CLK_HZ  (CLK_HZ),
  .WAIT_US (WAIT_US)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .byte_ready_o   (byte_ready_o),
  .prog_n_o       (prog_n_o),
  .cclk_o         (cclk_o),
  .din_o          (din_o),
  .busy_o         (busy_o),
  .status_valid_o (status_valid_o),
  .status_o       (status_o)
);

// File: tb/cfg_serial_loader_tb.sv
`timescale 1ns/1ps
module cfg_serial_loader_tb;

  localparam int CLK_HZ  = 50_000_000;
  localparam int CCLK_HZ = 12_500_000;
  localparam int WAIT_US = 4;
  localparam int CW      = 16;
  localparam int HALF    = 2;
  localparam int TMO     = 200;

  logic          clk, rst_n, start_i, byte_valid_i, init_n_i, done_i;
  logic [CW-1:0] total_bytes_i;
  logic [7:0]    byte_data_i;
  logic          byte_ready_o, prog_n_o, cclk_o, din_o, busy_o, status_valid_o;
  logic [2:0]    status_o;

  cfg_serial_loader #(.CLK_HZ(CLK_HZ), .CCLK_MAX_HZ(CCLK_HZ), .WAIT_US(WAIT_US),
                      .COUNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .total_bytes_i(total_bytes_i),
    .byte_data_i(byte_data_i), .byte_valid_i(byte_valid_i), .byte_ready_o(byte_ready_o),
    .prog_n_o(prog_n_o), .cclk_o(cclk_o), .din_o(din_o), .init_n_i(init_n_i),
    .done_i(done_i), .busy_o(busy_o), .status_valid_o(status_valid_o), .status_o(status_o));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int       m_ph;       // 0 idle 1 prog 2 release 3 fetch 4 shift 5 flush 6 finished
  int       m_wait, m_div, m_bits, m_rem, m_stat;
  bit       m_cclk, m_hs, m_on;
  bit [7:0] m_sh;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_wait = 0; m_div = 0; m_bits = 0; m_rem = 0; m_stat = 0;
      m_cclk = 0; m_hs = 0; m_sh = 0; m_on = 1;
    end else begin
      int  nph;
      bit  fault, expd, tick, fall;
      fault = !init_n_i && !done_i;
      expd  = (m_wait == TMO - 1);
      tick  = (m_ph == 4 || m_ph == 5) && (m_div == HALF - 1);
      fall  = tick && m_cclk;
      m_hs  = 0;
      nph   = m_ph;
      case (m_ph)
        0, 6: if (start_i) begin nph = 1; m_stat = 0; m_rem = int'(total_bytes_i); end
        1: if (!init_n_i) nph = 2; else if (expd) begin nph = 6; m_stat = 2; end
        2: if (init_n_i) nph = 3; else if (expd) begin nph = 6; m_stat = 3; end
        3: if (m_rem == 0) nph = 5;
           else if (fault) begin nph = 6; m_stat = 5; end
           else if (byte_valid_i) begin
             nph = 4; m_hs = 1; m_rem--; m_sh = byte_data_i; m_bits = 0;
           end
        4: if (fall) begin
             m_sh = m_sh << 1; m_bits++;
             if (m_bits == 8) nph = (m_rem == 0) ? 5 : 3;
           end
        5: if (done_i) begin nph = 6; m_stat = 1; end
           else if (expd) begin nph = 6; m_stat = 4; end
        default: nph = 0;
      endcase
      if (nph != m_ph) begin
        m_div = 0; m_cclk = 0; m_wait = 0;
      end else begin
        if (tick) begin m_div = 0; m_cclk = !m_cclk; end
        else if (m_ph == 4 || m_ph == 5) m_div++;
        if ((m_ph == 1 || m_ph == 2 || m_ph == 5) && m_wait < TMO - 1) m_wait++;
      end
      m_ph = nph;
    end
  end

  // per-cycle comparison (R1 R4 R7 R8 R3 R10)
  always @(negedge clk) begin
    if (m_on) begin
      bit e_rdy, e_din;
      e_rdy = (m_ph == 3) && (m_rem != 0) && !(!init_n_i && !done_i);
      e_din = (m_ph == 4) ? m_sh[7] : 1'b1;
      if (prog_n_o !== (m_ph != 1))
        check(0, "R1 prog_n", prog_n_o, m_ph != 1);
      else if (cclk_o !== m_cclk)
        check(0, "R4 cclk", cclk_o, m_cclk);
      else if (din_o !== e_din)
        check(0, "R4 din", din_o, e_din);
      else if (byte_ready_o !== e_rdy)
        check(0, "R7 ready", byte_ready_o, e_rdy);
      else if (busy_o !== (m_ph >= 1 && m_ph <= 5))
        check(0, "R8 busy", busy_o, m_ph >= 1 && m_ph <= 5);
      else if (status_valid_o !== (m_ph == 6))
        check(0, "R8 status_valid", status_valid_o, m_ph == 6);
      else if (int'(status_o) != m_stat)
        check(0, "R3 status", status_o, m_stat);
      else
        check(1, "cycle", 0, 0);
    end
  end

  // ---------------- target device and byte source ----------------
  int       dv_mode, dv_fault_after, dv_done_after, dv_nbytes, dv_gap;
  int       dv_lo, dv_hi, dv_bits, dv_flush, dv_flush_bad, gap_cnt;
  bit       dv_fault_on, dv_prev;
  bit [7:0] dv_acc;
  bit [7:0] cap_q[$];
  bit [7:0] src_q[$];

  always begin
    @(posedge clk);
    #1;
    cycles++;
    if (cycles > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
    if (m_hs) begin
      void'(src_q.pop_front());
      gap_cnt = dv_gap;
    end else if (gap_cnt > 0) gap_cnt--;
    byte_valid_i = (src_q.size() > 0) && (gap_cnt == 0);
    byte_data_i  = (src_q.size() > 0) ? src_q[0] : 8'h00;
    if (!prog_n_o) begin
      dv_lo++; dv_hi = 0; done_i = 0;
      if (dv_mode != 1 && dv_lo >= 3) init_n_i = 0;
    end else begin
      dv_lo = 0;
      if (!init_n_i && !dv_fault_on) begin
        dv_hi++;
        if (dv_mode != 2 && dv_hi >= 4) init_n_i = 1;
      end
    end
    if (cclk_o && !dv_prev) begin
      if (dv_bits < 8 * dv_nbytes) begin
        dv_acc = {dv_acc[6:0], din_o};
        dv_bits++;
        if (dv_bits % 8 == 0) begin
          cap_q.push_back(dv_acc);
          if (dv_fault_after >= 0 && cap_q.size() == dv_fault_after) begin
            init_n_i = 0; dv_fault_on = 1;
          end
        end
      end else begin
        dv_flush++;
        if (din_o !== 1'b1) dv_flush_bad++;
        if (dv_done_after >= 0 && dv_flush >= dv_done_after) done_i = 1;
      end
    end
    dv_prev = cclk_o;
  end

  task automatic run_case(input string tag, input bit [7:0] img[$], input int gap,
                          input int mode, input int fault_after, input int done_after,
                          input int exp_stat, input bit extra_start);
    int waited = 0;
    @(posedge clk); #2;
    dv_mode = mode; dv_fault_after = fault_after; dv_done_after = done_after;
    dv_nbytes = img.size(); dv_gap = gap; gap_cnt = 0;
    dv_lo = 0; dv_hi = 0; dv_bits = 0; dv_flush = 0; dv_flush_bad = 0;
    dv_fault_on = 0; cap_q.delete(); src_q = img;
    init_n_i = 1; done_i = 0;
    total_bytes_i = CW'(img.size());
    start_i = 1;
    @(posedge clk); #2;
    start_i = 0;
    if (extra_start) begin
      repeat (30) @(posedge clk);
      #2; start_i = 1; total_bytes_i = 16'd1;
      @(posedge clk); #2; start_i = 0;
    end
    while (!status_valid_o && waited < 20000) begin
      @(posedge clk); waited++;
    end
    @(negedge clk);
    check(status_valid_o === 1'b1, {tag, " status present"}, status_valid_o, 1);
    check(int'(status_o) == exp_stat, {tag, " final code"}, status_o, exp_stat);
    if (exp_stat == 1) begin
      check(cap_q.size() == img.size(), {tag, " R4 byte count"}, cap_q.size(), img.size());
      foreach (cap_q[i])
        check(cap_q[i] == img[i], {tag, " R4 MSB-first byte"}, cap_q[i], img[i]);
      check(dv_flush_bad == 0, {tag, " R6 din high in flush"}, dv_flush_bad, 0);
      check(dv_flush >= done_after, {tag, " R6 clocks until done"}, dv_flush, done_after);
    end
  endtask

  initial begin
    rst_n = 0; start_i = 0; total_bytes_i = '0; byte_valid_i = 0; byte_data_i = 0;
    init_n_i = 1; done_i = 0; dv_mode = 0; dv_fault_after = -1; dv_done_after = -1;
    dv_nbytes = 0; dv_gap = 0; gap_cnt = 0; dv_prev = 0; dv_acc = 0;
    dv_lo = 0; dv_hi = 0; dv_bits = 0; dv_flush = 0; dv_flush_bad = 0; dv_fault_on = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R10: idle values under reset
    check(prog_n_o === 1 && cclk_o === 0 && din_o === 1, "R10 reset link pins",
          {prog_n_o, cclk_o, din_o}, 3'b101);
    check(busy_o === 0 && byte_ready_o === 0 && status_valid_o === 0 && status_o === 0,
          "R10 reset status", {busy_o, byte_ready_o, status_valid_o}, 0);
    @(posedge clk); #2; rst_n = 1;

    run_case("R6 R7 back-to-back", '{8'hA5, 8'h3C, 8'h81}, 0, 0, -1, 5, 1, 0);
    run_case("R7 gapped stream",   '{8'h00, 8'hFF, 8'h5A, 8'hC3}, 7, 0, -1, 3, 1, 0);
    run_case("R9 zero bytes",      '{}, 0, 0, -1, 2, 1, 0);
    run_case("R1 init never low",  '{8'h12}, 0, 1, -1, 2, 2, 0);
    run_case("R2 init held low",   '{8'h12}, 0, 2, -1, 2, 3, 0);
    run_case("R5 fault mid-image", '{8'h11, 8'h22, 8'h33, 8'h44}, 0, 0, 2, 2, 5, 0);
    check(cap_q.size() == 2, "R5 bytes before fault", cap_q.size(), 2);
    run_case("R6 done never",      '{8'h6E}, 0, 0, -1, -1, 4, 0);
    run_case("R8 start while busy",'{8'hE7, 8'h18}, 2, 0, -1, 4, 1, 1);

    repeat (5) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule